// File: doc/BRIEF.md
# Cascaded Match-Address Output Arbiter

This block decides, for one device in a vertical chain of content-addressable memories, whether the device drives the shared address output bus and what value it puts there. After every memory cycle the device records the kind of cycle and the local address that belongs to it. There are four kinds of cycle: compare, write at the next free entry, read/write at the top-priority match, and random access. The block then settles which device owns the bus.

Ownership is decided by priority for compare, next-free and top-match cycles. A device drives the bus only if it has a valid local result and no device above it has one. This holds whatever the local output-enable pin says. A random-access result follows the output-enable pin alone.

A single-bit cascade chain carries "some higher device has a result" from device to device. When no device in the chain has a result, the device built as lowest priority drives an all-ones sentinel. The bus register updates only while the host enable strobe is high, and it holds its value while the strobe is low.

The internal result state machine has five states:

| State | Meaning |
|---|---|
| `RS_IDLE` | After reset; no cycle seen yet. |
| `RS_RANDOM` | A random-access cycle was recorded. |
| `RS_WIN` | This device owns the bus for a priority cycle. |
| `RS_YIELD` | A higher device owns the bus, or this device has no result and is not lowest. |
| `RS_SENTINEL` | No result anywhere and this device is lowest. |

Every recorded cycle moves the machine as follows:

- A random-access cycle goes to `RS_RANDOM`.
- A priority cycle with `casc_in` high goes to `RS_YIELD`.
- A priority cycle with `casc_in` low and the local flag set goes to `RS_WIN`.
- A priority cycle with neither goes to `RS_SENTINEL` when `IS_LAST` is 1, and to `RS_YIELD` when it is 0.

Without a recorded cycle the state holds.

Top module: `cam_aa_arbiter`

## Requirements
- R1: After reset `aa_oe` is 0 and `aa_out` is all zeros until a recorded cycle reaches the output.
- R2: `casc_out` equals `casc_in` ORed with the local flag, and is purely combinational. The local flag is `local_hit` for `cyc_type` 0 (compare) and 2 (top-priority match), and `local_free` for `cyc_type` 1 (write at next free). It is zero for `cyc_type` 3 (random access) and whenever `cyc_valid` is low.
- R3: For a priority cycle (`cyc_type` 0, 1 or 2) with `casc_in` low and the local flag set, the device drives `aa_out` regardless of `oe_n`. The value is `match_addr` for types 0 and 2, and `free_addr` for type 1.
- R4: For a priority cycle with `casc_in` high, `aa_oe` is 0 regardless of `oe_n` and of the local flags.
- R5: For a random-access cycle, `aa_out` shows `rnd_addr` and `aa_oe` is the inverse of `oe_n` as sampled at each output update.
- R6: For a compare or top-match cycle, consider the case where `casc_in` and `local_hit` are both low. A device with `IS_LAST`=1 drives all ones with `aa_oe` high. A device with `IS_LAST`=0 keeps `aa_oe` low.
- R7: For a next-free cycle with `casc_in` and `local_free` both low, the same sentinel rule as R6 applies.
- R8: A cycle is recorded at the rising edge where `cyc_valid` is high. The output registers load at each later rising edge where `strobe_n` is high, so a result reaches `aa_out`/`aa_oe` at the second edge when the strobe stays high. At an edge where `strobe_n` is low, `aa_out` and `aa_oe` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Host enable strobe; the output may change only while high |
| oe_n | input | 1 | Local active-low output enable |
| cyc_valid | input | 1 | A memory cycle completes this clock |
| cyc_type | input | 2 | 0 compare, 1 write next free, 2 top-match access, 3 random access |
| local_hit | input | 1 | Local search found a match |
| local_free | input | 1 | Local array has a free entry |
| match_addr | input | ADDR_W | Local top-priority match address |
| free_addr | input | ADDR_W | Local next-free address |
| rnd_addr | input | ADDR_W | Random-access address |
| casc_in | input | 1 | A higher-priority device has a result |
| casc_out | output | 1 | Result status passed to lower-priority devices |
| aa_out | output | ADDR_W | Address output value |
| aa_oe | output | 1 | Drive enable for the address output pads |

## Verification
The bench builds two copies from the same stimulus, one with `IS_LAST`=1 and one with `IS_LAST`=0, both with `ADDR_W`=13. Side by side, the two copies show that the all-ones sentinel appears only on the lowest device while the other device stays off the bus. Toggling `casc_in` and `oe_n` across all four cycle types covers the override of the local enable, and strobe-low windows that span a new cycle cover the hold rule.

// File: rtl/cam_aa_pkg.sv
package cam_aa_pkg;

    typedef enum logic [1:0] {
        CK_COMPARE   = 2'd0,
        CK_NEXT_FREE = 2'd1,
        CK_TOP_MATCH = 2'd2,
        CK_RANDOM    = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        RS_IDLE     = 3'd0,
        RS_RANDOM   = 3'd1,
        RS_WIN      = 3'd2,
        RS_YIELD    = 3'd3,
        RS_SENTINEL = 3'd4
    } res_state_e;

endpackage

// File: rtl/aa_casc_link.sv
module aa_casc_link
    import cam_aa_pkg::*;
(
    input  logic       cyc_valid,
    input  logic [1:0] cyc_type,
    input  logic       local_hit,
    input  logic       local_free,
    input  logic       casc_in,
    output logic       own_flag,
    output logic       casc_out
);

    always_comb begin
        own_flag = 1'b0;
        if (cyc_valid) begin
            unique case (cyc_kind_e'(cyc_type))
                CK_COMPARE,
                CK_TOP_MATCH: own_flag = local_hit;
                CK_NEXT_FREE: own_flag = local_free;
                CK_RANDOM:    own_flag = 1'b0;
                default:      own_flag = 1'b0;
            endcase
        end
    end

    assign casc_out = casc_in | own_flag;

    always_comb begin
        AST_CASC_PASS: assert (!casc_in || casc_out); // R2
    end

endmodule

// File: rtl/aa_result_fsm.sv
module aa_result_fsm
    import cam_aa_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter bit IS_LAST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [1:0]        cyc_type,
    input  logic              own_flag,
    input  logic              casc_in,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic [ADDR_W-1:0] free_addr,
    input  logic [ADDR_W-1:0] rnd_addr,
    output res_state_e        state,
    output logic [ADDR_W-1:0] addr_q
);

    res_state_e        state_nx;
    logic [ADDR_W-1:0] addr_nx;
    cyc_kind_e         kind;

    assign kind = cyc_kind_e'(cyc_type);

    always_comb begin
        state_nx = state;
        if (cyc_valid) begin
            unique case (kind)
                CK_RANDOM: state_nx = RS_RANDOM;
                CK_COMPARE,
                CK_NEXT_FREE,
                CK_TOP_MATCH: begin
                    if (casc_in)       state_nx = RS_YIELD;
                    else if (own_flag) state_nx = RS_WIN;
                    else if (IS_LAST)  state_nx = RS_SENTINEL;
                    else               state_nx = RS_YIELD;
                end
                default: state_nx = state;
            endcase
        end
    end

    always_comb begin
        addr_nx = addr_q;
        if (cyc_valid) begin
            unique case (kind)
                CK_COMPARE,
                CK_TOP_MATCH: addr_nx = match_addr;
                CK_NEXT_FREE: addr_nx = free_addr;
                CK_RANDOM:    addr_nx = rnd_addr;
                default:      addr_nx = addr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_nx;
    end

    AST_YIELD_ON_CASC: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && kind != CK_RANDOM && casc_in) |=> state == RS_YIELD); // R4
    AST_WIN_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && kind != CK_RANDOM && !casc_in && own_flag) |=> state == RS_WIN); // R3
    AST_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && kind != CK_RANDOM && !casc_in && !own_flag)
        |=> state == (IS_LAST ? RS_SENTINEL : RS_YIELD)); // R6
    AST_RANDOM_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && kind == CK_RANDOM) |=> state == RS_RANDOM); // R5

endmodule

// File: rtl/aa_out_latch.sv
module aa_out_latch
    import cam_aa_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              oe_n,
    input  res_state_e        state,
    input  logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] aa_out,
    output logic              aa_oe
);

    localparam logic [ADDR_W-1:0] SENTINEL = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] val_nx;
    logic              oe_nx;

    always_comb begin
        val_nx = addr_q;
        oe_nx  = 1'b0;
        unique case (state)
            RS_IDLE:     begin val_nx = addr_q;   oe_nx = 1'b0;  end
            RS_RANDOM:   begin val_nx = addr_q;   oe_nx = !oe_n; end
            RS_WIN:      begin val_nx = addr_q;   oe_nx = 1'b1;  end
            RS_YIELD:    begin val_nx = addr_q;   oe_nx = 1'b0;  end
            RS_SENTINEL: begin val_nx = SENTINEL; oe_nx = 1'b1;  end
            default:     begin val_nx = addr_q;   oe_nx = 1'b0;  end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aa_out <= '0;
            aa_oe  <= 1'b0;
        end else if (strobe_n) begin
            aa_out <= val_nx;
            aa_oe  <= oe_nx;
        end
    end

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |=> ($stable(aa_out) && $stable(aa_oe))); // R8
    AST_SENTINEL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n && state == RS_SENTINEL) |=> (aa_oe && aa_out == SENTINEL)); // R6
    AST_YIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n && state == RS_YIELD) |=> !aa_oe); // R4

endmodule

// File: rtl/cam_aa_arbiter.sv
module cam_aa_arbiter
    import cam_aa_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter bit IS_LAST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              oe_n,
    input  logic              cyc_valid,
    input  logic [1:0]        cyc_type,
    input  logic              local_hit,
    input  logic              local_free,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic [ADDR_W-1:0] free_addr,
    input  logic [ADDR_W-1:0] rnd_addr,
    input  logic              casc_in,
    output logic              casc_out,
    output logic [ADDR_W-1:0] aa_out,
    output logic              aa_oe
);

    logic              own_flag;
    res_state_e        state;
    logic [ADDR_W-1:0] addr_q;

    aa_casc_link u_link (
        .cyc_valid  (cyc_valid),
        .cyc_type   (cyc_type),
        .local_hit  (local_hit),
        .local_free (local_free),
        .casc_in    (casc_in),
        .own_flag   (own_flag),
        .casc_out   (casc_out)
    );

    aa_result_fsm #(
        .ADDR_W  (ADDR_W),
        .IS_LAST (IS_LAST)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_valid  (cyc_valid),
        .cyc_type   (cyc_type),
        .own_flag   (own_flag),
        .casc_in    (casc_in),
        .match_addr (match_addr),
        .free_addr  (free_addr),
        .rnd_addr   (rnd_addr),
        .state      (state),
        .addr_q     (addr_q)
    );

    aa_out_latch #(
        .ADDR_W (ADDR_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .oe_n     (oe_n),
        .state    (state),
        .addr_q   (addr_q),
        .aa_out   (aa_out),
        .aa_oe    (aa_oe)
    );

endmodule

// File: tb/test_cam_aa_arbiter.sv
module test_cam_aa_arbiter;

    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          cyc_valid = 1'b0;
    logic [1:0]    cyc_type = 2'd0;
    logic          local_hit = 1'b0;
    logic          local_free = 1'b0;
    logic [AW-1:0] match_addr = '0;
    logic [AW-1:0] free_addr = '0;
    logic [AW-1:0] rnd_addr = '0;
    logic          casc_in = 1'b0;

    logic          co_l, co_m, oe_l, oe_m;
    logic [AW-1:0] aa_l, aa_m;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cam_aa_arbiter #(.ADDR_W(AW), .IS_LAST(1'b1)) i_cam_aa_arbiter (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .oe_n(oe_n),
        .cyc_valid(cyc_valid), .cyc_type(cyc_type), .local_hit(local_hit),
        .local_free(local_free), .match_addr(match_addr), .free_addr(free_addr),
        .rnd_addr(rnd_addr), .casc_in(casc_in), .casc_out(co_l),
        .aa_out(aa_l), .aa_oe(oe_l));

    cam_aa_arbiter #(.ADDR_W(AW), .IS_LAST(1'b0)) i_cam_aa_arbiter_mid (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .oe_n(oe_n),
        .cyc_valid(cyc_valid), .cyc_type(cyc_type), .local_hit(local_hit),
        .local_free(local_free), .match_addr(match_addr), .free_addr(free_addr),
        .rnd_addr(rnd_addr), .casc_in(casc_in), .casc_out(co_m),
        .aa_out(aa_m), .aa_oe(oe_m));

    // Reference model: 0 idle, 1 random, 2 win, 3 yield, 4 sentinel
    int            m_st[2];
    int            m_kind[2];
    logic [AW-1:0] m_addr[2];
    logic [AW-1:0] m_aa[2];
    logic          m_oe[2];
    bit            m_held = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_st[i] = 0; m_kind[i] = 0; m_addr[i] = '0; m_aa[i] = '0; m_oe[i] = 1'b0;
            end
            m_held = 1'b0;
        end else begin
            m_held = !strobe_n;
            for (int i = 0; i < 2; i++) begin
                if (strobe_n) begin
                    m_oe[i] = (m_st[i] == 1) ? !oe_n : (m_st[i] == 2 || m_st[i] == 4);
                    m_aa[i] = (m_st[i] == 4) ? {AW{1'b1}} : m_addr[i];
                end
                if (cyc_valid) begin
                    m_kind[i] = cyc_type;
                    if (cyc_type == 2'd3) begin
                        m_st[i] = 1; m_addr[i] = rnd_addr;
                    end else begin
                        m_addr[i] = (cyc_type == 2'd1) ? free_addr : match_addr;
                        if (casc_in) m_st[i] = 3;
                        else if ((cyc_type == 2'd1) ? local_free : local_hit) m_st[i] = 2;
                        else m_st[i] = (i == 0) ? 4 : 3;
                    end
                end
            end
        end
    end

    function automatic string tag_of(int i);
        if (m_held) return "R8";
        case (m_st[i])
            0: return "R1";
            1: return "R5";
            2: return "R3";
            3: return "R4";
            default: return (m_kind[i] == 1) ? "R7" : "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [AW:0] act, input logic [AW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic fl;
            fl = cyc_valid && (cyc_type == 2'd1 ? local_free : (cyc_type == 2'd3 ? 1'b0 : local_hit));
            check("R2", "casc_out last", {{AW{1'b0}}, co_l}, {{AW{1'b0}}, casc_in | fl});
            check("R2", "casc_out mid",  {{AW{1'b0}}, co_m}, {{AW{1'b0}}, casc_in | fl});
            check(tag_of(0), "last oe",  {{AW{1'b0}}, oe_l}, {{AW{1'b0}}, m_oe[0]});
            check(tag_of(0), "last val", {1'b0, aa_l}, {1'b0, m_aa[0]});
            check(tag_of(1), "mid oe",   {{AW{1'b0}}, oe_m}, {{AW{1'b0}}, m_oe[1]});
            check(tag_of(1), "mid val",  {1'b0, aa_m}, {1'b0, m_aa[1]});
        end
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic do_cyc(input logic [1:0] t, input logic h, input logic f, input logic ci, input logic oe);
        cyc_type   = t;
        local_hit  = h;
        local_free = f;
        casc_in    = ci;
        oe_n       = oe;
        match_addr = AW'($urandom);
        free_addr  = AW'($urandom);
        rnd_addr   = AW'($urandom);
        cyc_valid  = 1'b1;
        step();
        cyc_valid  = 1'b0;
        step();
        step();
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        step();                                   // R1: idle outputs checked here
        do_cyc(2'd0, 1'b1, 1'b0, 1'b0, 1'b1);    // R3 compare win, oe_n high
        do_cyc(2'd2, 1'b1, 1'b0, 1'b0, 1'b1);    // R3 top-match win
        do_cyc(2'd1, 1'b0, 1'b1, 1'b0, 1'b1);    // R3 next-free win
        do_cyc(2'd0, 1'b1, 1'b1, 1'b1, 1'b0);    // R4 higher device owns, oe_n low
        do_cyc(2'd1, 1'b1, 1'b1, 1'b1, 1'b0);    // R4
        do_cyc(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);    // R6 no match anywhere
        do_cyc(2'd2, 1'b0, 1'b0, 1'b0, 1'b1);    // R6
        do_cyc(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);    // R7 system full
        do_cyc(2'd3, 1'b1, 1'b1, 1'b1, 1'b0);    // R5 random, driven
        do_cyc(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);    // R5 random, off
        oe_n = 1'b0; step(); step();             // R5 oe_n followed
        // R8: strobe low while a new cycle arrives, then release
        strobe_n = 1'b0;
        do_cyc(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        step();
        strobe_n = 1'b1;
        step(); step();
        for (int n = 0; n < 400; n++) begin
            cyc_valid  = ($urandom_range(0, 2) == 0);
            cyc_type   = 2'($urandom);
            local_hit  = 1'($urandom);
            local_free = 1'($urandom);
            casc_in    = 1'($urandom);
            oe_n       = 1'($urandom);
            strobe_n   = ($urandom_range(0, 3) != 0);
            match_addr = AW'($urandom);
            free_addr  = AW'($urandom);
            rnd_addr   = AW'($urandom);
            step();
        end
        cyc_valid = 1'b0;
        strobe_n  = 1'b1;
        step(); step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule